// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device-side virtual address into a physical address by reading two levels of translation entries from memory. A client presents a request carrying the virtual address, the ID of the master that issued it and whether the access is a read or a write. The walker first reads one 4-byte entry from a root directory of 4096 entries. That entry names a second-level table of 256 entries. The walker then reads one leaf entry from that table and returns the page frame joined with the page offset. It also returns the leaf's 4-bit permission-class index, which picks one of 16 classes.

Table entries are read over a simple port. A request is handed over on a valid/ready handshake, and the 32-bit data comes back on a single-cycle response strobe. The directory location comes from a root base register, which is loaded through a write strobe. If either level holds an invalid entry, the walk stops early. The response then carries a fault code and the virtual address that faulted. Only one walk is in flight at a time, and the request side is held off until the client takes the result.

Top module: `xlat_walker`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is high and both `mem_req_valid` and `rsp_valid` are low.
- R2: The first table read of a walk goes to root base + 4 × vaddr[31:20].
- R3: A directory entry is valid only when bits 1:0 hold 1 (binary 01). The values 0, 2 and 3 end the walk after that single read, with `rsp_fault` = 1 and `rsp_addr` = the request's virtual address.
- R4: For a valid directory entry, the second read goes to {entry[31:10], 10'b0} + 4 × vaddr[19:12]. Directory bits 9:2 have no effect.
- R5: A leaf entry whose bit 1 is 0 ends the walk with `rsp_fault` = 2 and `rsp_addr` = the request's virtual address.
- R6: For a leaf entry whose bit 1 is 1, `rsp_fault` = 0 and `rsp_addr` = {leaf[31:12], vaddr[11:0]}. Leaf bits 11:8, 3:2 and 0 have no effect.
- R7: `rsp_perm` is leaf bits 7:4 on a successful walk and 0 on any fault.
- R8: `rsp_master` and `rsp_write` return the master ID and direction of the request being answered.
- R9: Once a request is accepted, `req_ready` stays low until the response handshake completes. While `rsp_valid` is high and `rsp_ready` is low, every response field holds steady.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and `mem_req_addr` holds steady.
- R11: A write of `base_wdata` under `base_we` sets the root base used by every walk accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_we | input | 1 | Load strobe for the root base register |
| base_wdata | input | 32 | New root base value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_master | input | MID_W | ID of the requesting master |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Client accepts the result |
| rsp_addr | output | 32 | Physical address, or the faulting virtual address |
| rsp_perm | output | 4 | Permission-class index of the leaf |
| rsp_fault | output | 2 | 0 none, 1 directory fault, 2 leaf fault |
| rsp_master | output | MID_W | Master ID of the answered request |
| rsp_write | output | 1 | Direction of the answered request |

## Verification
The assertions that check stability take two things for granted. First, the memory returns one response strobe per accepted read, and that strobe comes at least one cycle after the read was accepted. Second, the root base register is not rewritten while a directory read is waiting for acceptance, because that address is formed live from the register. The stimulus respects both. Its memory model starts a response only on the clock edge after it has seen the handshake, with a latency of zero to two extra cycles. Base writes happen only between walks, while `req_ready` is high. Within these limits the stimulus sweeps every directory index, every leaf index under a second base, and several stall patterns on both handshakes.

// File: rtl/walk_pkg.sv
// Shared constants and types of the translation walker.
// Assumes a 32-bit address split into directory index, table index and
// page offset, with 4-byte table entries.
package walk_pkg;
    localparam int ADDR_W         = 32;
    localparam int OFF_W          = 12;
    localparam int TBL_IDX_W      = 8;
    localparam int DIR_IDX_W      = ADDR_W - OFF_W - TBL_IDX_W;
    localparam int ENTRY_LOG2     = 2;
    localparam int TBL_ALIGN      = TBL_IDX_W + ENTRY_LOG2;
    localparam int FRAME_W        = ADDR_W - OFF_W;
    localparam int PERM_LSB       = 4;
    localparam int PERM_W         = 4;
    localparam int DIR_VALID_W    = 2;
    localparam int DIR_VALID_CODE = 1;
    localparam int LEAF_VALID_BIT = 1;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DIR  = 2'd1,
        FLT_LEAF = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_LEAF_REQ,
        ST_LEAF_WAIT,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/walk_addr_gen.sv
// Entry address generator.
// Forms the byte address of the directory entry and of the leaf entry from
// the root base, the current table base and the virtual page number.
// Assumes entries of 2**ENTRY_LOG2 bytes and no carry limits on the adds.
module walk_addr_gen
    import walk_pkg::*;
(
    input  logic [ADDR_W-1:0]     root_base,
    input  logic [ADDR_W-1:0]     tbl_base,
    input  logic [ADDR_W-1:OFF_W] vpn,
    output logic [ADDR_W-1:0]     dir_entry_addr,
    output logic [ADDR_W-1:0]     leaf_entry_addr
);
    localparam int DIR_LSB = OFF_W + TBL_IDX_W;

    logic [DIR_IDX_W-1:0] dir_idx;
    logic [TBL_IDX_W-1:0] tbl_idx;

    // Split the page number and scale each index by the entry size.
    always_comb begin
        dir_idx         = vpn[ADDR_W-1:DIR_LSB];
        tbl_idx         = vpn[DIR_LSB-1:OFF_W];
        dir_entry_addr  = root_base + ADDR_W'({dir_idx, {ENTRY_LOG2{1'b0}}});
        leaf_entry_addr = tbl_base  + ADDR_W'({tbl_idx, {ENTRY_LOG2{1'b0}}});
    end
endmodule

// File: rtl/walk_entry_decode.sv
// Table entry decoder.
// Interprets one 32-bit word either as a directory entry (valid code plus
// a next-table pointer) or as a leaf entry (valid flag, frame, class).
// Reserved bits are deliberately dropped.
module walk_entry_decode
    import walk_pkg::*;
(
    input  logic [ADDR_W-1:0]  entry,
    output logic               dir_ok,
    output logic [ADDR_W-1:0]  next_tbl,
    output logic               leaf_ok,
    output logic [FRAME_W-1:0] frame,
    output logic [PERM_W-1:0]  perm
);
    logic unused_rsv;

    // Extract both views of the entry; the caller picks by walk level.
    always_comb begin
        dir_ok     = (entry[DIR_VALID_W-1:0] == DIR_VALID_W'(DIR_VALID_CODE));
        next_tbl   = {entry[ADDR_W-1:TBL_ALIGN], {TBL_ALIGN{1'b0}}};
        leaf_ok    = entry[LEAF_VALID_BIT];
        frame      = entry[ADDR_W-1:OFF_W];
        perm       = entry[PERM_LSB+PERM_W-1:PERM_LSB];
        unused_rsv = ^{entry[TBL_ALIGN-1:PERM_LSB+PERM_W],
                       entry[PERM_LSB-1:DIR_VALID_W]};
    end
endmodule

// File: rtl/xlat_walker.sv
// Two-level translation walker (top).
// Accepts one translation at a time, reads the directory entry and then
// the leaf entry over the memory read port, and reports a physical address
// with its permission class or a fault with the faulting address.
// Assumes one memory response per accepted read, at least a cycle later,
// and no root base write while a directory read awaits acceptance.
module xlat_walker
    import walk_pkg::*;
#(
    parameter int MID_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [31:0]       base_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic [MID_W-1:0]  req_master,
    input  logic              req_write,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_addr,
    output logic [3:0]        rsp_perm,
    output logic [1:0]        rsp_fault,
    output logic [MID_W-1:0]  rsp_master,
    output logic              rsp_write
);
    walk_state_e          state_q;
    logic [ADDR_W-1:0]    root_base_q;
    logic [ADDR_W-1:0]    va_q;
    logic [ADDR_W-1:0]    tbl_q;
    logic [ADDR_W-1:0]    out_addr_q;
    logic [PERM_W-1:0]    perm_q;
    fault_e               fault_q;
    logic [MID_W-1:0]     mid_q;
    logic                 wr_q;

    logic [ADDR_W-1:0]    dir_entry_addr;
    logic [ADDR_W-1:0]    leaf_entry_addr;
    logic                 dir_ok;
    logic [ADDR_W-1:0]    next_tbl;
    logic                 leaf_ok;
    logic [FRAME_W-1:0]   frame;
    logic [PERM_W-1:0]    leaf_perm;

    walk_addr_gen u_addr (
        .root_base       (root_base_q),
        .tbl_base        (tbl_q),
        .vpn             (va_q[ADDR_W-1:OFF_W]),
        .dir_entry_addr  (dir_entry_addr),
        .leaf_entry_addr (leaf_entry_addr)
    );

    walk_entry_decode u_dec (
        .entry    (mem_rsp_data),
        .dir_ok   (dir_ok),
        .next_tbl (next_tbl),
        .leaf_ok  (leaf_ok),
        .frame    (frame),
        .perm     (leaf_perm)
    );

    // Drive the handshake outputs from the walk state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_LEAF_REQ);
        mem_req_addr  = (state_q == ST_LEAF_REQ) ? leaf_entry_addr : dir_entry_addr;
        rsp_valid     = (state_q == ST_DONE);
        rsp_addr      = out_addr_q;
        rsp_perm      = perm_q;
        rsp_fault     = fault_q;
        rsp_master    = mid_q;
        rsp_write     = wr_q;
    end

    // Root base register, loaded by its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_base_q <= '0;
        end else if (base_we) begin
            root_base_q <= base_wdata;
        end
    end

    // Walk sequencer: accept, read directory, read leaf, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            va_q       <= '0;
            tbl_q      <= '0;
            out_addr_q <= '0;
            perm_q     <= '0;
            fault_q    <= FLT_NONE;
            mid_q      <= '0;
            wr_q       <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        mid_q   <= req_master;
                        wr_q    <= req_write;
                        state_q <= ST_DIR_REQ;
                    end
                end
                ST_DIR_REQ: begin
                    if (mem_req_ready) state_q <= ST_DIR_WAIT;
                end
                ST_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (dir_ok) begin
                            tbl_q   <= next_tbl;
                            state_q <= ST_LEAF_REQ;
                        end else begin
                            fault_q    <= FLT_DIR;
                            out_addr_q <= va_q;
                            perm_q     <= '0;
                            state_q    <= ST_DONE;
                        end
                    end
                end
                ST_LEAF_REQ: begin
                    if (mem_req_ready) state_q <= ST_LEAF_WAIT;
                end
                ST_LEAF_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (leaf_ok) begin
                            fault_q    <= FLT_NONE;
                            out_addr_q <= {frame, va_q[OFF_W-1:0]};
                            perm_q     <= leaf_perm;
                        end else begin
                            fault_q    <= FLT_LEAF;
                            out_addr_q <= va_q;
                            perm_q     <= '0;
                        end
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Accepting a request closes the request side at the next edge.
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // No new request while a result waits for the client.
    p_no_accept_with_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // A stalled result keeps every field.
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_perm)
            && $stable(rsp_fault) && $stable(rsp_master) && $stable(rsp_write));

    // A stalled table read keeps its address.
    p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // Faulted results carry no permission class.
    p_fault_no_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != 2'd0) |-> rsp_perm == '0);

    // Faulted results return the address under translation.
    p_fault_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != 2'd0) |-> rsp_addr == va_q);
endmodule

// File: tb/xlat_walker_test.sv
// Self-checking bench: a computed memory image, full directory sweep,
// leaf sweep under a second root base, stalls on both handshakes.
module xlat_walker_test;
    localparam int MID_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             base_we = 1'b0;
    logic [31:0]      base_wdata = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [31:0]      req_vaddr = '0;
    logic [MID_W-1:0] req_master = '0;
    logic             req_write = 1'b0;
    logic             mem_req_valid;
    logic             mem_req_ready;
    logic [31:0]      mem_req_addr;
    logic             mem_rsp_valid;
    logic [31:0]      mem_rsp_data;
    logic             rsp_valid;
    logic             rsp_ready = 1'b0;
    logic [31:0]      rsp_addr;
    logic [3:0]       rsp_perm;
    logic [1:0]       rsp_fault;
    logic [MID_W-1:0] rsp_master;
    logic             rsp_write;

    int vec = 0, bad = 0, mem_vec = 0, mem_bad = 0;
    logic [31:0] dir_base = 32'h1000_0000;
    int lat_sel = 0, stall_mod = 0;
    logic [31:0] rd_log [4];
    int rd_total = 0;

    xlat_walker #(.MID_W(MID_W)) uut (.*);

    always #10 clk = ~clk;

    // Directory entry for index i: table at 0x4000_0000 + 1 KiB * i.
    function automatic logic [31:0] dte_f(int i);
        logic [31:0] t = 32'h4000_0000 + 32'(i) * 32'd1024;
        logic [1:0] vb;
        case (i % 8)
            3: vb = 2'd0;
            5: vb = 2'd2;
            6: vb = 2'd3;
            default: vb = 2'd1;
        endcase
        return {t[31:10], 8'(i * 37 + 1), vb};
    endfunction

    // Leaf entry j of table t, reserved bits deliberately set.
    function automatic logic [31:0] pte_f(int t, int j);
        logic [19:0] fr = 20'(t * 37 + j * 5 + 32'h12345);
        logic v = ((t + 3 * j) % 7) != 2;
        return {fr, 4'h9, 4'((t ^ j) & 15), 2'b11, v, 1'b1};
    endfunction

    function automatic logic [31:0] model(logic [31:0] a);
        if (a >= dir_base && a < dir_base + 32'd16384)
            return dte_f(int'((a - dir_base) >> 2));
        if (a >= 32'h4000_0000 && a < 32'h4040_0000)
            return pte_f(int'((a - 32'h4000_0000) >> 10), int'((a >> 2) & 32'hFF));
        return 32'hDEAD_BEEF;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: accepts reads with a stall pattern, answers with latency.
    initial begin
        bit pend = 0, hs_prev = 0, stall_prev = 0;
        int cnt = 0, ctr = 0;
        logic [31:0] hs_addr = '0, stall_addr = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (hs_prev) begin
                pend = 1; cnt = lat_sel; hs_prev = 0;
            end
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = model(hs_addr);
                    pend = 0;
                end else cnt--;
            end
            if (stall_prev) begin
                mem_vec++;
                if (!mem_req_valid || mem_req_addr != stall_addr) begin
                    mem_bad++;
                    $display("FAIL R10 actual=%h expected=%h", mem_req_addr, stall_addr);
                end
            end
            ctr++;
            mem_req_ready = (stall_mod == 0) || (ctr % stall_mod != 0);
            if (mem_req_valid && mem_req_ready) begin
                hs_prev = 1;
                hs_addr = mem_req_addr;
                rd_log[rd_total % 4] = mem_req_addr;
                rd_total++;
            end
            stall_prev = mem_req_valid && !mem_req_ready;
            stall_addr = mem_req_addr;
        end
    end

    task automatic set_base(logic [31:0] b);
        @(negedge clk);
        base_we = 1'b1; base_wdata = b;
        @(negedge clk);
        base_we = 1'b0;
        dir_base = b;
    endtask

    task automatic walk(logic [31:0] va, logic [3:0] mid, bit wr, int hold);
        int start = rd_total;
        logic [31:0] dte, pte, tbl, e_addr;
        logic [1:0] e_flt;
        logic [3:0] e_perm;
        int e_rd;
        logic [31:0] c_addr;
        @(negedge clk);
        req_vaddr = va; req_master = mid; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 busy", 32'(req_ready), 32'd0);
        while (!rsp_valid) @(negedge clk);
        c_addr = rsp_addr;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_addr == c_addr && !req_ready, "R9 hold", rsp_addr, c_addr);
        end
        // expected values from the requirements
        dte = dte_f(int'(va[31:20]));
        if (dte[1:0] != 2'd1) begin
            e_flt = 2'd1; e_addr = va; e_perm = 4'd0; e_rd = 1;     // R3
        end else begin
            tbl = {dte[31:10], 10'b0};
            pte = pte_f(int'(va[31:20]), int'(va[19:12]));
            e_rd = 2;
            if (!pte[1]) begin
                e_flt = 2'd2; e_addr = va; e_perm = 4'd0;            // R5
            end else begin
                e_flt = 2'd0; e_addr = {pte[31:12], va[11:0]}; e_perm = pte[7:4]; // R6 R7
            end
            chk(rd_log[(start + 1) % 4] == tbl + {22'd0, va[19:12], 2'b00}, "R4 leaf addr",
                rd_log[(start + 1) % 4], tbl + {22'd0, va[19:12], 2'b00});
        end
        chk(rd_log[start % 4] == dir_base + {18'd0, va[31:20], 2'b00}, "R2/R11 dir addr",
            rd_log[start % 4], dir_base + {18'd0, va[31:20], 2'b00});
        chk(rd_total - start == e_rd, "R3 read count", 32'(rd_total - start), 32'(e_rd));
        chk(rsp_fault == e_flt, "R3/R5 fault", 32'(rsp_fault), 32'(e_flt));
        chk(rsp_addr == e_addr, "R6 addr", rsp_addr, e_addr);
        chk(rsp_perm == e_perm, "R7 perm", 32'(rsp_perm), 32'(e_perm));
        chk(rsp_master == mid && rsp_write == wr, "R8 id/dir",
            {rsp_master, 27'd0, rsp_write}, {mid, 27'd0, wr});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R9 release", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_req_valid && !rsp_valid, "R1 reset",
            {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !rsp_valid, "R1 after reset",
            {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'b100);
        set_base(32'h1000_0000);
        for (int d = 0; d < 4096; d++) begin
            lat_sel = d % 3;
            stall_mod = ((d / 8) % 4 == 1) ? 2 : ((d / 8) % 4 == 2) ? 3 : 0;
            walk({12'(d), 8'(d * 13 + 7), 12'(d * 97)}, 4'(d), d[4], d % 3);
        end
        set_base(32'h2000_0000);                                     // R11
        for (int t = 0; t < 512; t++) begin
            lat_sel = t % 2;
            stall_mod = (t % 5 == 0) ? 2 : 0;
            walk({(t < 256) ? 12'd9 : 12'd12, 8'(t), 12'(t * 41)}, 4'(t + 3), t[0], t % 2);
        end
        stall_mod = 0;
        walk(32'h0000_0000, 4'd0, 1'b0, 0);
        walk(32'hFFFF_FFFF, 4'd15, 1'b1, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vec + mem_vec, bad + mem_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vec + mem_vec + 1, bad + mem_bad);
        $finish;
    end
endmodule